// File: doc/BRIEF.md
# Byte-Parallel x^43+1 Scrambler and Descrambler Pair

This block holds two independent datapaths for a packet-over-SONET link. The transmit path scrambles every octet headed for the line: flags, payload and check sequence are all scrambled alike. The receive path reverses the process on octets that arrive from the line. Each path handles one 8-bit octet per clock whenever its data-enable is high.

Each path has its own bypass control. The polynomial is x^43 + 1, so each line bit is the data bit XORed with the line bit that went out 43 bit-times before it. Within an octet, bit 7 comes first in time and bit 0 comes last.

The descrambler takes its history from the line bits it receives. Its history register keeps tracking the line even while descrambling is switched off. For that reason it is already synchronized on the cycle its enable is raised. It needs no seed, and it gives the original data back after any 43 received bits. Both paths add exactly one register stage, whether or not they are enabled.

Top module: `x43_scrambler_pair`

## Requirements
- R1: With the scrambler enabled, transmit line bit n equals data bit n XOR line bit n-43. Bits are counted in time order, and bit 7 of each octet is the earliest bit of that octet.
- R2: With the descrambler enabled, the received output bit n equals line bit n XOR line bit n-43, using the same ordering as R1.
- R3: With the scrambler disabled, the transmit line octet equals the input octet. The latency is the same single clock as the enabled path.
- R4: With the descrambler disabled, the receive output octet equals the input line octet. The latency is the same single clock as the enabled path.
- R5: The descrambler history keeps absorbing line octets while descrambling is off. If the enable is raised after at least 43 line bits have arrived, the very next octet is already recovered correctly.
- R6: A history register advances only on cycles where its path's data-enable is high. Idle cycles leave the scrambling sequence unchanged.
- R7: Each output valid equals its input data-enable delayed by one clock. While that output valid is low, the output data holds its last value.
- R8: Synchronous active-high reset clears both output valids, both output data buses and both history registers. As a result, the first 40 scrambled bits after reset equal the data bits.
- R9: A descrambler whose history disagrees with the scrambler's recovers the plaintext exactly, from the first whole octet that begins 43 or more bits into the stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both paths |
| rst | input | 1 | Synchronous active-high reset |
| tx_valid | input | 1 | Transmit octet present this cycle |
| tx_scr_en | input | 1 | 1 = scramble, 0 = pass the octet through |
| tx_data | input | 8 | Transmit octet from the framer |
| tx_line_valid | output | 1 | Line octet valid |
| tx_line_data | output | 8 | Scrambled line octet |
| rx_line_valid | input | 1 | Received line octet present this cycle |
| rx_dscr_en | input | 1 | 1 = descramble, 0 = pass the octet through |
| rx_line_data | input | 8 | Received line octet |
| rx_valid | output | 1 | Recovered octet valid |
| rx_data | output | 8 | Recovered octet |

## Verification
The bench builds the block with its default parameters: an 8-bit octet and a 43-bit lag.

With these values the lag is five whole octets plus three bits. That offset lets the bench check three things that a lag of a whole number of octets would hide:
- the bit-order rule within an octet;
- the 40-bit pass-through window right after reset;
- the partial-octet boundary at which a mismatched descrambler starts to match the plaintext.

A bit-serial reference model in the bench, indexed by absolute bit count, supplies every expected octet.

// File: rtl/x43_scr_pkg.sv
package x43_scr_pkg;

    localparam int unsigned OCTET_W = 8;
    localparam int unsigned LAG_BITS = 43;

    typedef enum logic {
        DIR_SCRAMBLE   = 1'b0,
        DIR_DESCRAMBLE = 1'b1
    } lane_dir_e;

    typedef struct packed {
        logic beat;
        logic active;
    } lane_ctl_t;

endpackage

// File: rtl/x43_out_stage.sv
module x43_out_stage #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         beat,
    input  logic [W-1:0] nxt_data,
    output logic         q_valid,
    output logic [W-1:0] q_data
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q_valid <= 1'b0;
            q_data  <= '0;
        end else begin
            q_valid <= beat;
            if (beat) begin
                q_data <= nxt_data;
            end
        end
    end

endmodule

// File: rtl/x43_lane.sv
module x43_lane
    import x43_scr_pkg::*;
#(
    parameter int unsigned W   = OCTET_W,
    parameter int unsigned TAP = LAG_BITS,
    parameter lane_dir_e   DIR = DIR_SCRAMBLE
) (
    input  logic         clk,
    input  logic         rst,
    input  lane_ctl_t    ctl,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    output logic [W-1:0] out_data
);

    localparam bit FEED_FROM_OUT = (DIR == DIR_SCRAMBLE);

    logic [TAP-1:0] hist_q;
    logic [TAP-1:0] hist_d;
    logic [W-1:0]   mix;

    // Walk the octet from bit W-1 (earliest) down to bit 0 (latest).
    always_comb begin
        logic [TAP-1:0] h;
        logic           tap_bit;
        logic           ob;
        logic           feed;
        h   = hist_q;
        mix = '0;
        for (int k = W - 1; k >= 0; k--) begin
            tap_bit = h[TAP-1];
            ob      = ctl.active ? (in_data[k] ^ tap_bit) : in_data[k];
            feed    = FEED_FROM_OUT ? ob : in_data[k];
            mix[k]  = ob;
            h       = {h[TAP-2:0], feed};
        end
        hist_d = h;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q <= '0;
        end else if (ctl.beat) begin
            hist_q <= hist_d;
        end
    end

    x43_out_stage #(.W(W)) u_out (
        .clk     (clk),
        .rst     (rst),
        .beat    (ctl.beat),
        .nxt_data(mix),
        .q_valid (out_valid),
        .q_data  (out_data)
    );

endmodule

// File: rtl/x43_scrambler_pair.sv
module x43_scrambler_pair
    import x43_scr_pkg::*;
#(
    parameter int unsigned W   = OCTET_W,
    parameter int unsigned TAP = LAG_BITS
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tx_valid,
    input  logic         tx_scr_en,
    input  logic [W-1:0] tx_data,
    output logic         tx_line_valid,
    output logic [W-1:0] tx_line_data,
    input  logic         rx_line_valid,
    input  logic         rx_dscr_en,
    input  logic [W-1:0] rx_line_data,
    output logic         rx_valid,
    output logic [W-1:0] rx_data
);

    lane_ctl_t tx_ctl;
    lane_ctl_t rx_ctl;

    assign tx_ctl = '{beat: tx_valid, active: tx_scr_en};
    assign rx_ctl = '{beat: rx_line_valid, active: rx_dscr_en};

    x43_lane #(.W(W), .TAP(TAP), .DIR(DIR_SCRAMBLE)) u_tx (
        .clk      (clk),
        .rst      (rst),
        .ctl      (tx_ctl),
        .in_data  (tx_data),
        .out_valid(tx_line_valid),
        .out_data (tx_line_data)
    );

    x43_lane #(.W(W), .TAP(TAP), .DIR(DIR_DESCRAMBLE)) u_rx (
        .clk      (clk),
        .rst      (rst),
        .ctl      (rx_ctl),
        .in_data  (rx_line_data),
        .out_valid(rx_valid),
        .out_data (rx_data)
    );

endmodule

// File: rtl/x43_pair_checker.sv
module x43_pair_checker #(
    parameter int unsigned W   = 8,
    parameter int unsigned TAP = 43
) (
    input logic         clk,
    input logic         rst,
    input logic         tx_valid,
    input logic         tx_scr_en,
    input logic [W-1:0] tx_data,
    input logic         tx_line_valid,
    input logic [W-1:0] tx_line_data,
    input logic         rx_line_valid,
    input logic         rx_dscr_en,
    input logic [W-1:0] rx_line_data,
    input logic         rx_valid,
    input logic [W-1:0] rx_data
);

    // Records of line octets seen at the ports; the newest bit sits at index 0.
    logic [TAP-1:0] tx_rec;
    logic [TAP-1:0] rx_rec;
    logic [W-1:0]   rx_mask_now;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_rec <= '0;
            rx_rec <= '0;
        end else begin
            if (tx_line_valid) tx_rec <= {tx_rec[TAP-W-1:0], tx_line_data};
            if (rx_line_valid) rx_rec <= {rx_rec[TAP-W-1:0], rx_line_data};
        end
    end

    assign rx_mask_now = rx_rec[TAP-1 -: W];

    // R7
    assert_tx_valid_delay_R7: assert property (@(posedge clk) disable iff (rst)
        tx_line_valid == $past(tx_valid));
    assert_rx_valid_delay_R7: assert property (@(posedge clk) disable iff (rst)
        rx_valid == $past(rx_line_valid));
    assert_tx_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !tx_line_valid |-> $stable(tx_line_data));

    // R1
    assert_tx_law_R1: assert property (@(posedge clk) disable iff (rst)
        tx_line_valid && $past(tx_scr_en) |->
            tx_line_data == ($past(tx_data) ^ tx_rec[TAP-1 -: W]));

    // R2
    assert_rx_law_R2: assert property (@(posedge clk) disable iff (rst)
        rx_valid && $past(rx_dscr_en) |->
            rx_data == ($past(rx_line_data) ^ $past(rx_mask_now)));

    // R3
    assert_tx_bypass_R3: assert property (@(posedge clk) disable iff (rst)
        tx_line_valid && !$past(tx_scr_en) |-> tx_line_data == $past(tx_data));

    // R4
    assert_rx_bypass_R4: assert property (@(posedge clk) disable iff (rst)
        rx_valid && !$past(rx_dscr_en) |-> rx_data == $past(rx_line_data));

endmodule

bind x43_scrambler_pair x43_pair_checker #(.W(W), .TAP(TAP)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .tx_valid     (tx_valid),
    .tx_scr_en    (tx_scr_en),
    .tx_data      (tx_data),
    .tx_line_valid(tx_line_valid),
    .tx_line_data (tx_line_data),
    .rx_line_valid(rx_line_valid),
    .rx_dscr_en   (rx_dscr_en),
    .rx_line_data (rx_line_data),
    .rx_valid     (rx_valid),
    .rx_data      (rx_data)
);

// File: tb/x43_scrambler_pair_test.sv
module x43_scrambler_pair_test;

    localparam int LAG = 43;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tx_valid = 1'b0, tx_scr_en = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic       tx_line_valid;
    logic [7:0] tx_line_data;
    logic       rx_line_valid = 1'b0, rx_dscr_en = 1'b0;
    logic [7:0] rx_line_data = 8'h00;
    logic       rx_valid;
    logic [7:0] rx_data;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    x43_scrambler_pair uut (
        .clk(clk), .rst(rst),
        .tx_valid(tx_valid), .tx_scr_en(tx_scr_en), .tx_data(tx_data),
        .tx_line_valid(tx_line_valid), .tx_line_data(tx_line_data),
        .rx_line_valid(rx_line_valid), .rx_dscr_en(rx_dscr_en), .rx_line_data(rx_line_data),
        .rx_valid(rx_valid), .rx_data(rx_data)
    );

    // Bit-serial reference: absolute bit histories of the line on each side.
    logic tx_bits [0:4095];
    logic rx_bits [0:4095];
    int   tx_n = 0;
    int   rx_n = 0;
    logic [7:0] tx_prev = 8'h00;
    logic [7:0] rx_prev = 8'h00;

    function automatic logic [7:0] tx_model(input logic [7:0] d, input logic en);
        logic [7:0] r;
        logic       old;
        for (int k = 7; k >= 0; k--) begin
            old = (tx_n >= LAG) ? tx_bits[tx_n - LAG] : 1'b0;
            r[k] = en ? (d[k] ^ old) : d[k];
            tx_bits[tx_n] = r[k];
            tx_n++;
        end
        return r;
    endfunction

    function automatic logic [7:0] rx_model(input logic [7:0] c, input logic en);
        logic [7:0] r;
        logic       old;
        for (int k = 7; k >= 0; k--) begin
            old = (rx_n >= LAG) ? rx_bits[rx_n - LAG] : 1'b0;
            r[k] = en ? (c[k] ^ old) : c[k];
            rx_bits[rx_n] = c[k];
            rx_n++;
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [8:0] got, input logic [8:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Called at a falling edge: drive one beat on both paths, then check at the next falling edge.
    task automatic beat(input logic tv, input logic ten, input logic [7:0] td,
                        input logic rv, input logic ren, input logic [7:0] rd,
                        input string treq, input string rreq);
        logic [7:0] te, re;
        tx_valid = tv; tx_scr_en = ten; tx_data = td;
        rx_line_valid = rv; rx_dscr_en = ren; rx_line_data = rd;
        te = tv ? tx_model(td, ten) : tx_prev;
        re = rv ? rx_model(rd, ren) : rx_prev;
        @(negedge clk);
        check(treq, {tx_line_valid, tx_line_data}, {tv, te});
        check(rreq, {rx_valid, rx_data}, {rv, re});
        tx_prev = te;
        rx_prev = re;
        tx_valid = 1'b0;
        rx_line_valid = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        tx_valid = 0; tx_scr_en = 0; tx_data = 0;
        rx_line_valid = 0; rx_dscr_en = 0; rx_line_data = 0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        tx_n = 0; rx_n = 0; tx_prev = 0; rx_prev = 0;
        check("R8 tx after reset", {tx_line_valid, tx_line_data}, 9'h000);
        check("R8 rx after reset", {rx_valid, rx_data}, 9'h000);
    endtask

    // Stimulus table: {tv, ten, td, rv, ren, rd}
    localparam logic [19:0] VEC [16] = '{
        {1'b1, 1'b1, 8'h7E, 1'b1, 1'b1, 8'h3C},
        {1'b1, 1'b1, 8'hFF, 1'b1, 1'b1, 8'h81},
        {1'b1, 1'b0, 8'h5A, 1'b1, 1'b0, 8'h96},
        {1'b0, 1'b1, 8'h11, 1'b0, 1'b1, 8'h22},
        {1'b1, 1'b1, 8'h80, 1'b1, 1'b1, 8'h01},
        {1'b1, 1'b1, 8'h01, 1'b1, 1'b1, 8'h80},
        {1'b1, 1'b1, 8'hC3, 1'b0, 1'b0, 8'hEE},
        {1'b0, 1'b0, 8'h99, 1'b1, 1'b1, 8'h7D},
        {1'b1, 1'b1, 8'h7D, 1'b1, 1'b1, 8'h5D},
        {1'b1, 1'b0, 8'h00, 1'b1, 1'b1, 8'hA5},
        {1'b1, 1'b1, 8'hAA, 1'b1, 1'b0, 8'h55},
        {1'b1, 1'b1, 8'h55, 1'b1, 1'b1, 8'hF0},
        {1'b1, 1'b1, 8'h0F, 1'b1, 1'b1, 8'h0F},
        {1'b1, 1'b1, 8'h12, 1'b1, 1'b1, 8'h34},
        {1'b1, 1'b1, 8'hE7, 1'b1, 1'b1, 8'hB6},
        {1'b1, 1'b1, 8'h3B, 1'b1, 1'b1, 8'h6D}
    };

    logic [7:0] plain [0:23];
    logic [7:0] line  [0:23];

    initial begin
        // R8 reset state and R6/R7 via table walk; R1..R4 by reference model.
        @(negedge clk);
        do_reset();
        for (int i = 0; i < 16; i++) begin
            beat(VEC[i][19], VEC[i][18], VEC[i][17:10],
                 VEC[i][9], VEC[i][8], VEC[i][7:0],
                 "R1/R3/R6/R7 tx", "R2/R4/R6/R7 rx");
        end

        // R6: idle cycles hold the sequence; R7: data held while invalid.
        repeat (3) beat(1'b0, 1'b1, 8'hEE, 1'b0, 1'b1, 8'hEE, "R7 tx idle hold", "R7 rx idle hold");
        for (int i = 0; i < 4; i++)
            beat(1'b1, 1'b1, 8'h20 + 8'(i), 1'b1, 1'b1, 8'h40 + 8'(i), "R6 tx after idle", "R6 rx after idle");

        // R8: first 40 bits after reset pass unchanged; then R5 descrambler tracking while off.
        do_reset();
        for (int i = 0; i < 12; i++) begin
            plain[i] = 8'h3A ^ 8'(i * 29);
            beat(1'b1, 1'b1, plain[i], 1'b0, 1'b0, 8'h00, "R1 tx", "R7 rx idle");
            line[i] = tx_line_data;
            if (i < 5) check("R8 early octet unchanged", {1'b0, line[i]}, {1'b0, plain[i]});
        end
        for (int i = 0; i < 12; i++) begin
            beat(1'b0, 1'b0, 8'h00, 1'b1, (i >= 6), line[i], "R7 tx idle", "R5 rx");
            if (i < 6) check("R4 disabled rx passes line", {1'b0, rx_data}, {1'b0, line[i]});
            else       check("R5 recovered at enable", {1'b0, rx_data}, {1'b0, plain[i]});
        end

        // R9: descrambler history mismatched with scrambler history.
        do_reset();
        for (int i = 0; i < 9; i++)
            beat(1'b1, 1'b1, 8'hC5 ^ 8'(i), 1'b0, 1'b0, 8'h00, "R1 tx warmup", "R7 rx idle");
        for (int i = 0; i < 16; i++) begin
            plain[i] = 8'h6B + 8'(i * 13);
            beat(1'b1, 1'b1, plain[i], 1'b0, 1'b0, 8'h00, "R1 tx", "R7 rx idle");
            line[i] = tx_line_data;
        end
        for (int i = 0; i < 16; i++) begin
            beat(1'b0, 1'b0, 8'h00, 1'b1, 1'b1, line[i], "R7 tx idle", "R2 rx");
            if (i >= 6) check("R9 self-sync recovery", {1'b0, rx_data}, {1'b0, plain[i]});
        end

        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule